// File: doc/BRIEF.md
# Oversampled Serial Receiver with Per-Character Status Queue

This block receives asynchronous serial characters and hands them to a host through a small queue. A state machine samples the serial line once per oversample tick, with sixteen ticks to one bit. It checks each start bit, assembles eight data bits (least significant bit first), an optional parity bit and one stop bit in a hidden shift register, and then marks the character as complete. A completed character moves into a one-character hold stage. From there it enters a four-entry data queue whenever space is free. A second queue of the same depth moves in lockstep with the first. It holds four flags for each character: parity error, framing error, overrun and break.

The host sees the oldest character on `rd_data` and that character's flags on `rd_stat`. `rd_valid` is high while the queue holds anything. A one-cycle `rd_en` pulse removes the oldest entry from both queues at once. When the queue is full, one more character can wait in the hold stage. A further character that completes before the hold stage drains replaces the waiting one and carries the overrun flag.

The state machine has the states IDLE, START, DATA, PARITY, STOP and WAITHI. Its transitions are:
- IDLE to START when a tick sees the line low.
- START to IDLE when the line is high again at mid-bit (a rejected glitch).
- START to DATA when the line is still low at mid-bit.
- DATA to PARITY after the eighth bit when parity is enabled.
- DATA to STOP after the eighth bit when parity is disabled.
- PARITY to STOP after the parity bit is sampled.
- STOP to IDLE when the stop bit is sampled high.
- STOP to WAITHI when the stop bit is sampled low.
- WAITHI to IDLE when the line returns high.

Top module: `rxs_top`

## Requirements
- R1: A start is accepted only if the line is still low on the 8th tick after the tick that first saw it low. Each following bit is sampled 16 ticks after the previous sample point. There are 8 data bits, least significant bit first, then a parity bit when `par_en` is 1, then one stop bit.
- R2: A low pulse on the line that is high again at the start-bit mid-point produces no character.
- R3: Completed characters enter a 4-entry queue in arrival order. `rd_valid` is 1 while the queue is non-empty. `rd_data` shows the oldest character, and `rd_stat` shows its flags with bit0 = parity error, bit1 = framing error, bit2 = overrun and bit3 = break.
- R4: A cycle with `rd_en` high and `rd_valid` high removes the oldest data and its status together. `rd_en` while the queue is empty has no effect.
- R5: With the queue full, one further character is held and enters the queue after the next read.
- R6: If a character completes while the hold stage is still occupied and the queue is full, the held character is lost. The new character takes its place with `rd_stat` bit2 set.
- R7: With `par_en` = 1, bit0 is set when the XOR of the eight data bits, the parity bit and `par_odd` is 1 (`par_odd` = 0 selects even parity, 1 selects odd parity). With `par_en` = 0, bit0 is 0.
- R8: A stop bit sampled low sets bit1. The receiver then ignores the line until it has returned high.
- R9: A frame in which every sampled bit is low, including the stop bit and the parity bit if present, sets bit3 and bit1 and stores 00H.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| os_tick | input | 1 | Oversample enable, 16 per bit time |
| rxd | input | 1 | Serial line, idle high |
| par_en | input | 1 | Parity bit present when 1 |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| rd_en | input | 1 | Read strobe, removes the oldest entry |
| rd_valid | output | 1 | Queue holds at least one character |
| rd_data | output | 8 | Oldest character |
| rd_stat | output | 4 | Flags of the oldest character |

## Verification
A character is complete one clock after the tick at the stop-bit mid-point. It reaches the hold stage on the next edge and the queue on the edge after that, so the outputs change about three cycles after that tick. The bench therefore checks outputs only after at least two further bit times of idle line. After a read, a waiting character needs two edges to appear, so the bench waits two falling edges after each read strobe before it compares values. All sampling happens on the falling clock edge, away from the edges where the design updates.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_PARITY,
        S_STOP,
        S_WAITHI
    } rx_state_e;

    localparam int STAT_W  = 4;
    localparam int ST_PE   = 0;
    localparam int ST_FE   = 1;
    localparam int ST_OVR  = 2;
    localparam int ST_BRK  = 3;
endpackage

// File: rtl/rxs_frame.sv
module rxs_frame
    import rxs_pkg::*;
#(
    parameter int DBITS = 8,
    parameter int OSR   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             rxd,
    input  logic             par_en,
    input  logic             par_odd,
    output logic             done,
    output logic [DBITS-1:0] data,
    output logic             pe,
    output logic             fe,
    output logic             brk
);
    localparam int CW   = $clog2(OSR);
    localparam int BW   = $clog2(DBITS);
    localparam logic [CW-1:0] HALF_M1 = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] FULL_M1 = CW'(OSR - 1);
    localparam logic [BW-1:0] LAST_B  = BW'(DBITS - 1);

    rx_state_e        state_q, state_d;
    logic [CW-1:0]    cnt;
    logic [BW-1:0]    bitn;
    logic [DBITS-1:0] sh;
    logic             pbit;
    logic             mid;

    assign mid = tick && (cnt == FULL_M1);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (tick && !rxd) state_d = S_START;
            S_START:  if (tick && cnt == HALF_M1) state_d = rxd ? S_IDLE : S_DATA;
            S_DATA:   if (mid && bitn == LAST_B) state_d = par_en ? S_PARITY : S_STOP;
            S_PARITY: if (mid) state_d = S_STOP;
            S_STOP:   if (mid) state_d = rxd ? S_IDLE : S_WAITHI;
            S_WAITHI: if (rxd) state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            bitn <= '0;
            sh   <= '0;
            pbit <= 1'b0;
            done <= 1'b0;
            data <= '0;
            pe   <= 1'b0;
            fe   <= 1'b0;
            brk  <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    cnt  <= '0;
                    bitn <= '0;
                    pbit <= 1'b0;
                end
                S_START: if (tick) cnt <= (cnt == HALF_M1) ? '0 : cnt + 1'b1;
                S_DATA: if (tick) begin
                    cnt <= cnt + 1'b1;
                    if (cnt == FULL_M1) begin
                        sh   <= {rxd, sh[DBITS-1:1]};
                        bitn <= bitn + 1'b1;
                    end
                end
                S_PARITY: if (tick) begin
                    cnt <= cnt + 1'b1;
                    if (cnt == FULL_M1) pbit <= rxd;
                end
                S_STOP: if (tick) begin
                    cnt <= cnt + 1'b1;
                    if (cnt == FULL_M1) begin
                        done <= 1'b1;
                        data <= sh;
                        pe   <= par_en & ((^sh) ^ pbit ^ par_odd);
                        fe   <= !rxd;
                        brk  <= !rxd && (sh == '0) && !(par_en && pbit);
                    end
                end
                S_WAITHI: cnt <= '0;
                default:  cnt <= '0;
            endcase
        end
    end

    a_r2_start_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_START && tick && cnt == HALF_M1 && rxd) |=> state_q == S_IDLE);
    a_r9_brk_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && brk) |-> (fe && data == '0));
    a_r8_wait_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WAITHI && !rxd) |=> state_q == S_WAITHI);
endmodule

// File: rtl/rxs_fifo.sv
module rxs_fifo #(
    parameter int W     = 12,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [AW:0]   count;
    logic          pop;

    assign empty   = (count == '0);
    assign full    = (count == (AW+1)'(DEPTH));
    assign pop     = rd_en && !empty;
    assign rd_data = mem[rptr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (wr_en) begin
                wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            end
            if (pop) begin
                rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            end
            if (wr_en && !pop)      count <= count + 1'b1;
            else if (pop && !wr_en) count <= count - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[wptr] <= wr_data;
    end

    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !full);
    a_r3_fill_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !rd_en) |=> count == $past(count) + 1'b1);
    a_r4_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && empty && !wr_en) |=> empty);
endmodule

// File: rtl/rxs_top.sv
module rxs_top
    import rxs_pkg::*;
#(
    parameter int DBITS = 8,
    parameter int OSR   = 16,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             os_tick,
    input  logic             rxd,
    input  logic             par_en,
    input  logic             par_odd,
    input  logic             rd_en,
    output logic             rd_valid,
    output logic [DBITS-1:0] rd_data,
    output logic [STAT_W-1:0] rd_stat
);
    localparam int EW = DBITS + STAT_W;

    logic             done, pe, fe, brk;
    logic [DBITS-1:0] fdata;
    logic             hold_vld;
    logic [DBITS-1:0] hold_data;
    logic [STAT_W-1:0] hold_stat;
    logic             push, empty, full;
    logic [EW-1:0]    head;

    rxs_frame #(.DBITS(DBITS), .OSR(OSR)) u_frame (
        .clk(clk), .rst_n(rst_n), .tick(os_tick), .rxd(rxd),
        .par_en(par_en), .par_odd(par_odd),
        .done(done), .data(fdata), .pe(pe), .fe(fe), .brk(brk)
    );

    assign push = hold_vld && !full;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_vld  <= 1'b0;
            hold_data <= '0;
            hold_stat <= '0;
        end else if (done) begin
            hold_vld              <= 1'b1;
            hold_data             <= fdata;
            hold_stat[ST_PE]      <= pe;
            hold_stat[ST_FE]      <= fe;
            hold_stat[ST_BRK]     <= brk;
            hold_stat[ST_OVR]     <= hold_vld && !push;
        end else if (push) begin
            hold_vld <= 1'b0;
        end
    end

    rxs_fifo #(.W(EW), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .wr_en(push), .wr_data({hold_stat, hold_data}),
        .rd_en(rd_en), .rd_data(head),
        .empty(empty), .full(full)
    );

    assign rd_valid = !empty;
    assign rd_data  = head[DBITS-1:0];
    assign rd_stat  = head[EW-1:DBITS];

    a_r6_ovr_mark: assert property (@(posedge clk) disable iff (!rst_n)
        (done && hold_vld && full) |=> (hold_vld && hold_stat[ST_OVR]));
    a_r5_hold_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_vld && full && !done) |=> hold_vld);
endmodule

// File: tb/tb_rxs_top.sv
module tb_rxs_top;
    localparam int CLK_P = 10;
    localparam int BITC  = 32;

    logic       clk = 1'b0, rst_n = 1'b0, os_tick = 1'b0, rxd = 1'b1;
    logic       par_en = 1'b0, par_odd = 1'b0, rd_en = 1'b0;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic [3:0] rd_stat;
    int vecs = 0, bad = 0;

    rxs_top dut (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
        .par_en(par_en), .par_odd(par_odd), .rd_en(rd_en),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_stat(rd_stat)
    );

    always #(CLK_P/2) clk = ~clk;
    always @(negedge clk) os_tick <= ~os_tick;

    task automatic chk(input string req, input logic [12:0] act, input logic [12:0] exp);
        vecs++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input logic pon, input logic pb, input logic stopb);
        rxd = 1'b0; idle(BITC);
        for (int i = 0; i < 8; i++) begin rxd = d[i]; idle(BITC); end
        if (pon) begin rxd = pb; idle(BITC); end
        rxd = stopb; idle(BITC);
        rxd = 1'b1; idle(2 * BITC);
    endtask

    task automatic pop();
        rd_en = 1'b1; @(negedge clk); rd_en = 1'b0; @(negedge clk); @(negedge clk);
    endtask

    function automatic logic [12:0] expv(input logic [7:0] d, input logic pe, input logic fe,
                                         input logic ov, input logic bk);
        return {1'b1, bk, ov, fe, pe, d};
    endfunction

    initial begin
        #(CLK_P * 150000);
        bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end

    initial begin
        logic [7:0] cs [6];
        idle(4);
        rst_n = 1'b1;
        idle(2);
        chk("R3 reset empty", {12'h0, rd_valid}, 13'h0);

        // R4: read on empty has no effect
        pop();
        chk("R4 empty read", {12'h0, rd_valid}, 13'h0);

        // R1 R7: sweep data and parity modes, good and corrupted parity
        for (int m = 0; m < 3; m++) begin
            par_en  = (m != 0);
            par_odd = (m == 2);
            for (int k = 0; k < 16; k++) begin
                for (int f = 0; f < 2; f++) begin
                    logic [7:0] d;
                    logic pb, pe;
                    d  = 8'(k * 37 + 5);
                    pb = (^d) ^ par_odd ^ f[0];
                    pe = par_en & ((^d) ^ pb ^ par_odd);
                    send(d, par_en, pb, 1'b1);
                    chk("R1 R7 char", {rd_valid, rd_stat, rd_data}, expv(d, pe, 1'b0, 1'b0, 1'b0));
                    pop();
                    chk("R4 pop empties", {12'h0, rd_valid}, 13'h0);
                end
            end
        end

        // R2: short low pulse ignored
        par_en = 1'b0; par_odd = 1'b0;
        rxd = 1'b0; idle(10); rxd = 1'b1; idle(12 * BITC);
        chk("R2 glitch", {12'h0, rd_valid}, 13'h0);

        // R8: framing error, stop low
        send(8'hA5, 1'b0, 1'b0, 1'b0);
        chk("R8 framing", {rd_valid, rd_stat, rd_data}, expv(8'hA5, 1'b0, 1'b1, 1'b0, 1'b0));
        pop();

        // R9: break with even parity enabled, all zero
        par_en = 1'b1;
        send(8'h00, 1'b1, 1'b0, 1'b0);
        chk("R9 break", {rd_valid, rd_stat, rd_data}, expv(8'h00, 1'b0, 1'b1, 1'b0, 1'b1));
        pop();
        // R9: zero data with parity bit high is not a break
        send(8'h00, 1'b1, 1'b1, 1'b0);
        chk("R9 no break", {rd_valid, rd_stat, rd_data}, expv(8'h00, 1'b1, 1'b1, 1'b0, 1'b0));
        pop();
        par_en = 1'b0;

        // R3 R5 R6: fill, hold, overrun
        for (int i = 0; i < 6; i++) cs[i] = 8'(8'h31 + i * 29);
        for (int i = 0; i < 6; i++) begin
            send(cs[i], 1'b0, 1'b0, 1'b1);
            if (i == 3)
                chk("R3 full oldest", {rd_valid, rd_stat, rd_data}, expv(cs[0], 1'b0, 1'b0, 1'b0, 1'b0));
        end
        for (int i = 0; i < 4; i++) begin
            chk("R3 order", {rd_valid, rd_stat, rd_data}, expv(cs[i], 1'b0, 1'b0, 1'b0, 1'b0));
            pop();
        end
        chk("R6 overrun char", {rd_valid, rd_stat, rd_data}, expv(cs[5], 1'b0, 1'b0, 1'b1, 1'b0));
        pop();
        chk("R6 lost char gone", {12'h0, rd_valid}, 13'h0);

        // R5: one held character drains after read
        for (int i = 0; i < 5; i++) send(cs[i], 1'b0, 1'b0, 1'b1);
        for (int i = 0; i < 5; i++) begin
            chk("R5 held drains", {rd_valid, rd_stat, rd_data}, expv(cs[i], 1'b0, 1'b0, 1'b0, 1'b0));
            pop();
        end
        chk("R5 empty after", {12'h0, rd_valid}, 13'h0);

        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
    end
endmodule